// File: doc/BRIEF.md
# Lowest-Free Receive Mailbox Store

This block takes CAN frames that a bus receiver has already decoded and checked, and places each one into a bank of receive mailboxes. An arriving frame goes to the lowest-numbered mailbox that meets three conditions: it is enabled, its acceptance filter matches the frame, and it can take the frame. A mailbox in plain receive mode can take a frame only while it is empty. A mailbox in overwrite mode can always take one, and it raises a lost-message flag when it replaces a frame that nobody has read. A filled plain mailbox keeps its frame until the host re-arms it. A single write of a bitmask to the arm register re-arms any number of mailboxes at once.

Frames come in on a valid/ready stream. The block never applies back-pressure: `rx_ready` is always high, and a frame is taken in every cycle in which `rx_valid` is high. If no mailbox can take the frame, it is discarded. The host reaches the mailboxes through a simple register port. Writes take effect at the clock edge, and reads are combinational from `reg_addr`. Each mailbox has a 0x20-byte window at 0x200 + 0x20·i. The ready flags of all mailboxes are also available as a vector on `mb_ready`.

Top module: `rx_mailbox_alloc`

## Requirements
- R1: A frame on the stream goes to the lowest-index mailbox that is eligible. A mailbox is eligible when its filter accepts the frame and either it is in mode 1 (receive) and empty, or it is in mode 2 (receive with overwrite).
- R2: Once a mode 1 mailbox holds a frame, it takes no further frames and its stored contents do not change until it is re-armed.
- R3: Writing to address 0x024 re-arms mailbox i for each set bit i of the written data, which clears its ready and lost flags. Bits at or above the mailbox count have no effect.
- R4: A mode 2 mailbox that is ready still takes frames. When a capture replaces an unread frame, the lost flag (status bit 24) is set. Re-arming clears the lost flag.
- R5: The status word at window offset 0x10 has the DLC in bits 19:16, RTR in bit 20, ready in bit 23 and lost in bit 24. All other bits read as 0.
- R6: The received identifier at offset 0x0C has bit 29 set for extended format. An extended ID occupies bits 28:0; a standard 11-bit ID occupies bits 28:18.
- R7: The mask register is at offset 0x04 and uses bits 28:0. The filter identifier is at offset 0x08 and uses the same layout as R6. A frame is accepted when its format bit equals filter bit 29 and every ID bit selected by the mask matches. A mask of 0 accepts any ID of the matching format.
- R8: The mode register is at offset 0x00, with the mode in bits 26:24: 0 or 3..7 disabled, 1 receive, 2 overwrite. A disabled mailbox never takes a frame. Any write to the mode register clears the ready and lost flags.
- R9: A frame that no mailbox can take is discarded, and no mailbox state changes.
- R10: Data bytes 0..3 read at offset 0x14 and bytes 4..7 at offset 0x18, with byte 0 in bits 7:0. Stream byte k is `rx_data[8k+7:8k]`. Reads of unmapped addresses return 0.
- R11: `rx_ready` is always 1. When an arm write and a capture hit the same mailbox in one cycle, the capture wins: the mailbox ends ready, and its lost flag is not set.
- R12: `mb_ready[i]` equals the ready flag of mailbox i. After reset, every mailbox is disabled and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Frame present on the stream |
| rx_ready | output | 1 | Block can take a frame (always 1) |
| rx_ext | input | 1 | Frame uses the extended (29-bit) ID format |
| rx_id | input | 29 | Frame ID; standard frames use bits 10:0 |
| rx_rtr | input | 1 | Remote request flag |
| rx_dlc | input | 4 | Data length code |
| rx_data | input | 64 | Data bytes, byte k in bits 8k+7:8k |
| reg_we | input | 1 | Host write strobe |
| reg_addr | input | 12 | Host byte address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, combinational from reg_addr |
| mb_ready | output | 12 | Ready flag of each mailbox |

## Verification
Two functions can act in the same cycle: a host re-arm (or configuration write) and a frame capture. The bench provokes this by re-arming the full overwrite mailbox in the very cycle a frame arrives for it. It then checks that the mailbox ends ready without the lost flag. It also checks that a mailbox freed in the same cycle as a capture is not picked, because eligibility uses the state before the edge. A behavioural model in the bench steps with every transaction and is compared with the ready vector on each clock, and with status, ID and data readbacks.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;
  localparam int ID_W = 29;
  localparam int IDR_W = ID_W + 1;

  localparam logic [2:0] MODE_OFF = 3'd0;
  localparam logic [2:0] MODE_RX  = 3'd1;
  localparam logic [2:0] MODE_OVR = 3'd2;

  // frame in register form: bit 29 format, identifier aligned as stored
  typedef struct packed {
    logic [IDR_W-1:0] idr;
    logic             rtr;
    logic [3:0]       dlc;
    logic [63:0]      data;
  } frame_t;

  function automatic logic [IDR_W-1:0] to_idr(logic ext, logic [ID_W-1:0] id);
    return ext ? {1'b1, id} : {1'b0, id[10:0], 18'b0};
  endfunction

  function automatic logic filt_hit(logic [IDR_W-1:0] f, logic [ID_W-1:0] mask,
                                    logic [IDR_W-1:0] want);
    return (f[ID_W] == want[ID_W]) &&
           (((f[ID_W-1:0] ^ want[ID_W-1:0]) & mask) == '0);
  endfunction
endpackage

// File: rtl/mb_pick.sv
module mb_pick #(
  parameter int N = 12
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign gnt[i]    = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end
endmodule

// File: rtl/mb_slot.sv
module mb_slot
  import rxmb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_we,
  input  logic             mask_we,
  input  logic             fid_we,
  input  logic [31:0]      wdata,
  input  logic             arm,
  input  logic             capture,
  input  frame_t           frm,
  output logic             eligible,
  output logic [2:0]       mode_q,
  output logic [ID_W-1:0]  mask_q,
  output logic [IDR_W-1:0] fid_q,
  output logic             ready_q,
  output logic             lost_q,
  output frame_t           store_q
);
  logic can_take;

  always_comb begin
    can_take = (mode_q == MODE_OVR) || ((mode_q == MODE_RX) && !ready_q);
    eligible = can_take && filt_hit(frm.idr, mask_q, fid_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_OFF;
      mask_q  <= '0;
      fid_q   <= '0;
      ready_q <= 1'b0;
      lost_q  <= 1'b0;
      store_q <= '0;
    end else begin
      if (mode_we) begin
        mode_q  <= wdata[26:24];
        ready_q <= 1'b0;
        lost_q  <= 1'b0;
      end
      if (mask_we) mask_q <= wdata[ID_W-1:0];
      if (fid_we)  fid_q  <= wdata[IDR_W-1:0];
      if (arm) begin
        ready_q <= 1'b0;
        lost_q  <= 1'b0;
      end
      if (capture) begin
        ready_q <= 1'b1;
        if (ready_q && !arm) lost_q <= 1'b1;
        store_q <= frm;
      end
    end
  end

  // R2: a filled mailbox keeps its flag unless the host touches it
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q && !arm && !mode_we |=> ready_q);
  // R2: stored contents only change on a capture
  p_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(store_q));
  // R3: re-arm without a capture empties the mailbox
  p_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arm && !capture |=> !ready_q && !lost_q);
  // R4: lost only rises after a capture into a full mailbox
  p_lost_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_q) |-> $past(capture) && $past(ready_q));
  // R8: only an enabled mailbox is ever selected
  p_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (mode_q == MODE_RX) || (mode_q == MODE_OVR));
endmodule

// File: rtl/rx_mailbox_alloc.sv
module rx_mailbox_alloc
  import rxmb_pkg::*;
#(
  parameter int NUM_MB   = 12,
  parameter int ADDR_W   = 12,
  parameter int WIN_BASE = 'h200,
  parameter int ARM_ADDR = 'h024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              rx_ext,
  input  logic [28:0]       rx_id,
  input  logic              rx_rtr,
  input  logic [3:0]        rx_dlc,
  input  logic [63:0]       rx_data,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NUM_MB-1:0] mb_ready
);
  localparam int WIN_SH  = 5;
  localparam int BLK_W   = ADDR_W - WIN_SH;
  localparam int BASE_BK = WIN_BASE >> WIN_SH;
  localparam int ARM_W   = (NUM_MB < 32) ? NUM_MB : 32;

  frame_t frm;
  logic [NUM_MB-1:0] elig, gnt, cap, arm_vec;
  logic [2:0]        mode_a  [NUM_MB];
  logic [ID_W-1:0]   mask_a  [NUM_MB];
  logic [IDR_W-1:0]  fid_a   [NUM_MB];
  logic              lost_a  [NUM_MB];
  frame_t            store_a [NUM_MB];
  logic              arm_hit;

  assign rx_ready = 1'b1;
  assign frm = '{idr: to_idr(rx_ext, rx_id), rtr: rx_rtr, dlc: rx_dlc, data: rx_data};
  assign arm_hit = reg_we && (reg_addr == ADDR_W'(ARM_ADDR));

  always_comb begin
    arm_vec = '0;
    if (arm_hit) arm_vec[ARM_W-1:0] = reg_wdata[ARM_W-1:0];
  end

  mb_pick #(.N(NUM_MB)) u_pick (.req(elig), .gnt(gnt));

  assign cap = rx_valid ? gnt : '0;

  for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
    logic sel;
    assign sel = (reg_addr[ADDR_W-1:WIN_SH] == BLK_W'(BASE_BK + i));

    mb_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_we  (reg_we && sel && (reg_addr[WIN_SH-1:0] == 5'h00)),
      .mask_we  (reg_we && sel && (reg_addr[WIN_SH-1:0] == 5'h04)),
      .fid_we   (reg_we && sel && (reg_addr[WIN_SH-1:0] == 5'h08)),
      .wdata    (reg_wdata),
      .arm      (arm_vec[i]),
      .capture  (cap[i]),
      .frm      (frm),
      .eligible (elig[i]),
      .mode_q   (mode_a[i]),
      .mask_q   (mask_a[i]),
      .fid_q    (fid_a[i]),
      .ready_q  (mb_ready[i]),
      .lost_q   (lost_a[i]),
      .store_q  (store_a[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_MB; i++) begin
      if (reg_addr[ADDR_W-1:WIN_SH] == BLK_W'(BASE_BK + i)) begin
        case (reg_addr[WIN_SH-1:0])
          5'h00: reg_rdata = {5'b0, mode_a[i], 24'b0};
          5'h04: reg_rdata = {3'b0, mask_a[i]};
          5'h08: reg_rdata = {2'b0, fid_a[i]};
          5'h0C: reg_rdata = {2'b0, store_a[i].idr};
          5'h10: reg_rdata = {7'b0, lost_a[i], mb_ready[i], 2'b0,
                              store_a[i].rtr, store_a[i].dlc, 16'b0};
          5'h14: reg_rdata = store_a[i].data[31:0];
          5'h18: reg_rdata = store_a[i].data[63:32];
          default: reg_rdata = '0;
        endcase
      end
    end
  end

  // R1: a frame with any eligible mailbox lands in exactly the lowest one
  p_lowest_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && (elig != '0) |-> $onehot(cap) && ((elig & (cap - 1'b1)) == '0));
  // R9: a frame nobody takes leaves the ready vector alone
  p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && (elig == '0) && !reg_we |=> $stable(mb_ready));
  // R12: reset leaves every mailbox empty
  p_reset_r12: assert property (@(posedge clk)
    $rose(rst_n) |-> (mb_ready == '0));
endmodule

// File: tb/rx_mailbox_alloc_tb.sv
`timescale 1ns/1ps
module rx_mailbox_alloc_tb;
  localparam int N = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_ext = 1'b0, rx_rtr = 1'b0;
  logic [28:0] rx_id = '0;
  logic [3:0]  rx_dlc = '0;
  logic [63:0] rx_data = '0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        rx_ready;
  logic [31:0] reg_rdata;
  logic [N-1:0] mb_ready;

  int total = 0, bad = 0;
  bit live = 0;

  always #4 clk = ~clk;

  rx_mailbox_alloc u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_ext(rx_ext), .rx_id(rx_id), .rx_rtr(rx_rtr), .rx_dlc(rx_dlc),
    .rx_data(rx_data), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mb_ready(mb_ready)
  );

  // behavioural reference state
  int          m_mode [N];
  logic [28:0] m_mask [N];
  logic [29:0] m_fid  [N];
  bit          m_rdy  [N];
  bit          m_lost [N];
  logic [29:0] m_id   [N];
  bit          m_rtr  [N];
  logic [3:0]  m_dlc  [N];
  logic [63:0] m_dat  [N];

  function automatic int wa(int i, int off);
    return 'h200 + i * 'h20 + off;
  endfunction

  function automatic logic [N-1:0] exp_rdy();
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++) v[i] = m_rdy[i];
    return v;
  endfunction

  function automatic logic [31:0] exp_status(int i);
    logic [31:0] s = '0;
    s[19:16] = m_dlc[i];
    s[20] = m_rtr[i];
    s[23] = m_rdy[i];
    s[24] = m_lost[i];
    return s;
  endfunction

  function automatic bit b_match(int i, bit ext, logic [28:0] id);
    logic [28:0] v;
    v = ext ? id : {id[10:0], 18'h0};
    return (ext == m_fid[i][29]) && ((v & m_mask[i]) == (m_fid[i][28:0] & m_mask[i]));
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R11 / R12: ready vector and stream ready compared every clock
  always @(negedge clk) if (live) begin
    check(mb_ready == exp_rdy(), "R12 mb_ready", 64'(mb_ready), 64'(exp_rdy()));
    check(rx_ready == 1'b1, "R11 rx_ready", 64'(rx_ready), 64'd1);
  end

  task automatic step(bit fv, bit fe, logic [28:0] fid, bit frtr, logic [3:0] fdlc,
                      logic [63:0] fdat, bit wv, int waddr, logic [31:0] wdat);
    int win;
    bit rdy_pre [N];
    logic [N-1:0] armv;
    @(negedge clk);
    rx_valid = fv; rx_ext = fe; rx_id = fid; rx_rtr = frtr; rx_dlc = fdlc; rx_data = fdat;
    reg_we = wv; reg_addr = 12'(waddr); reg_wdata = wdat;
    @(posedge clk);
    win = -1;
    for (int i = 0; i < N; i++) begin
      rdy_pre[i] = m_rdy[i];
      if (fv && win < 0 && b_match(i, fe, fid) &&
          ((m_mode[i] == 1 && !m_rdy[i]) || m_mode[i] == 2)) win = i;
    end
    armv = '0;
    if (wv) begin
      if (waddr == 'h024) armv = wdat[N-1:0];
      else if (waddr >= 'h200 && waddr < 'h200 + N * 'h20) begin
        int idx = (waddr - 'h200) / 'h20;
        int off = (waddr - 'h200) % 'h20;
        if (off == 0) begin m_mode[idx] = int'(wdat[26:24]); m_rdy[idx] = 0; m_lost[idx] = 0; end
        if (off == 4) m_mask[idx] = wdat[28:0];
        if (off == 8) m_fid[idx] = wdat[29:0];
      end
    end
    for (int i = 0; i < N; i++) if (armv[i]) begin m_rdy[i] = 0; m_lost[i] = 0; end
    if (win >= 0) begin
      if (rdy_pre[win] && !armv[win]) m_lost[win] = 1;
      m_rdy[win] = 1;
      m_id[win]  = fe ? {1'b1, fid} : {1'b0, fid[10:0], 18'h0};
      m_rtr[win] = frtr; m_dlc[win] = fdlc; m_dat[win] = fdat;
    end
    @(negedge clk);
    rx_valid = 0; reg_we = 0;
  endtask

  task automatic wr(int a, logic [31:0] d);
    step(0, 0, '0, 0, '0, '0, 1, a, d);
  endtask

  task automatic frame(bit fe, logic [28:0] id, bit frtr, logic [3:0] dlc, logic [63:0] d);
    step(1, fe, id, frtr, dlc, d, 0, 0, '0);
  endtask

  task automatic rd(int a, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_addr = 12'(a);
    #1;
    check(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic rd_mb(int i, string tag);
    rd(wa(i, 'h10), exp_status(i), tag);
    rd(wa(i, 'h0C), {2'b0, m_id[i]}, tag);
    rd(wa(i, 'h14), m_dat[i][31:0], tag);
    rd(wa(i, 'h18), m_dat[i][63:32], tag);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_mode[i] = 0; m_mask[i] = '0; m_fid[i] = '0; m_rdy[i] = 0; m_lost[i] = 0;
      m_id[i] = '0; m_rtr[i] = 0; m_dlc[i] = '0; m_dat[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    live = 1;
    // R12: reset state
    rd(wa(0, 0), 32'h0, "R12 reset mode");
    rd(wa(7, 'h10), 32'h0, "R12 reset status");

    // configure: 0..3 plain ext any-ID, 5 exact standard 0x123, 11 overwrite ext
    for (int i = 0; i < 4; i++) begin
      wr(wa(i, 0), 32'h0100_0000);
      wr(wa(i, 8), 32'h2000_0000);
    end
    wr(wa(5, 0), 32'h0100_0000);
    wr(wa(5, 4), 32'h1FFC_0000);
    wr(wa(5, 8), 32'h123 << 18);
    wr(wa(11, 0), 32'h0200_0000);
    wr(wa(11, 8), 32'h2000_0000);
    rd(wa(5, 4), 32'h1FFC_0000, "R7 mask readback");
    rd(wa(11, 0), 32'h0200_0000, "R8 mode readback");

    // R1 / R5 / R6 / R10: first ext frame fills mailbox 0
    frame(1, 29'h1ABC_DEF0, 0, 4'd8, 64'h8877_6655_4433_2211);
    check(mb_ready == 12'h001, "R1 first to mb0", 64'(mb_ready), 64'h001);
    rd_mb(0, "R5 R6 R10 mb0 contents");

    // R1: fill upward, R7 mask 0 takes any extended ID
    frame(1, 29'h0000_0001, 1, 4'd0, 64'h0);
    frame(1, 29'h1FFF_FFFF, 0, 4'd3, 64'h0000_0000_00CC_BBAA);
    frame(1, 29'h0055_AA55, 0, 4'd15, 64'hFFEE_DDCC_BBAA_9988);
    check(mb_ready == 12'h00F, "R1 fill 0..3", 64'(mb_ready), 64'h00F);
    rd_mb(1, "R5 rtr in mb1");
    // R2: mb0 unchanged after later frames
    rd_mb(0, "R2 mb0 kept");

    // R4: overwrite mailbox takes the next two, second sets lost
    frame(1, 29'h0000_1111, 0, 4'd2, 64'h1111);
    rd_mb(11, "R4 first into overwrite");
    frame(1, 29'h0000_2222, 0, 4'd5, 64'h2222);
    rd(wa(11, 'h10), exp_status(11), "R4 lost set");
    check(exp_status(11)[24] == 1'b1, "R4 model lost", 64'(exp_status(11)), 64'h0100_0000);

    // R6 / R7: standard frame to exact filter
    frame(0, 29'h123, 1, 4'd1, 64'h77);
    rd_mb(5, "R6 R7 standard into mb5");
    // R9 / R7: unmatched standard frame dropped
    frame(0, 29'h124, 0, 4'd1, 64'h99);
    check(mb_ready == 12'h82F, "R9 drop no change", 64'(mb_ready), 64'h82F);
    rd_mb(5, "R9 mb5 untouched");

    // R3: re-arm 0 and 2 with one write; bit 15 ignored
    wr('h024, 32'h0000_8005);
    check(mb_ready == 12'h82A, "R3 arm mask", 64'(mb_ready), 64'h82A);
    frame(1, 29'h0BAD_CAFE, 0, 4'd6, 64'h0606);
    frame(1, 29'h0BAD_BEEF, 0, 4'd7, 64'h0707);
    check(mb_ready == 12'h82F, "R1 refill lowest", 64'(mb_ready), 64'h82F);
    rd_mb(0, "R1 mb0 new frame");
    rd_mb(2, "R1 mb2 new frame");

    // R11: arm and capture of mb11 in the same cycle; capture wins, no lost
    step(1, 1, 29'h0000_3333, 0, 4'd4, 64'h3333, 1, 'h024, 32'h0000_0800);
    rd(wa(11, 'h10), exp_status(11), "R11 capture wins");
    check(mb_ready[11] == 1'b1, "R11 mb11 ready", 64'(mb_ready), 64'h82F);

    // R11: freeing mb1 in the capture cycle does not make it eligible yet
    step(1, 1, 29'h0000_4444, 0, 4'd1, 64'h4444, 1, 'h024, 32'h0000_0002);
    check(mb_ready == 12'h82D, "R11 pre-edge eligibility", 64'(mb_ready), 64'h82D);
    rd(wa(11, 'h10), exp_status(11), "R4 lost after overwrite");

    // R3 / R4: re-arm clears lost
    wr('h024, 32'h0000_0800);
    rd(wa(11, 'h10), exp_status(11), "R4 arm clears lost");

    // R8: disabling mb5 clears it and stops it taking frames
    wr(wa(5, 0), 32'h0000_0000);
    frame(0, 29'h123, 0, 4'd2, 64'h55);
    check(mb_ready[5] == 1'b0, "R8 disabled no capture", 64'(mb_ready), 64'(exp_rdy()));
    rd(wa(5, 'h10), exp_status(5), "R8 status cleared");

    // R10: unmapped addresses read zero
    rd('h030, 32'h0, "R10 unmapped low");
    rd(wa(3, 'h1C), 32'h0, "R10 unmapped window slot");
    rd('h200 + N * 'h20, 32'h0, "R10 past last window");

    @(negedge clk);
    live = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule